// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a clocked host and an asynchronous static RAM organised as 16-bit words with 19 address lines. The host issues a request in a single cycle: a strobe, a write flag, a two-bit lane mask, an address and write data. The controller then plays out a correctly timed cycle on the memory pins and signals completion with a one-cycle done pulse. For reads it also returns the captured word.

Each memory phase is sized in clock cycles from the RAM's minimum nanosecond timing and the clock period. The phases are the read access, the write-enable pulse, and the bus release/turnaround. The rounding is always upward, so a faster clock only adds cycles. The controller never drives the shared data bus while the RAM may still be driving it.

The bus is presented as separate output data, output-enable and input data signals. The bidirectional pad buffer lives in the chip's I/O ring. All memory-side outputs come straight from flops.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_be_n` is all ones, `mem_dq_oe` is 0, `done` is 0 and `rd_data` is 0.
- R2: A read with a nonzero mask holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for exactly RD_CYC cycles. RD_CYC is the ceiling of T_ACC_PS / CLK_PERIOD_PS. During the read, `mem_be_n[i]` is low exactly when `req_mask[i]` is 1. Bit 1 is the upper lane, data bits 15..8. Bit 0 is the lower lane, data bits 7..0.
- R3: The read word is sampled from `mem_dq_i` on the last cycle of the access. Lanes whose mask bit is 0 return zero in `rd_data`.
- R4: After a read, chip select and output enable stay high for TA_CYC cycles before `done`. TA_CYC is the ceiling of T_HZ_PS / CLK_PERIOD_PS. `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and it rises only in a cycle after one with `mem_oe_n` high.
- R5: A write first holds `mem_cs_n` low with both `mem_we_n` and `mem_oe_n` high and `mem_dq_oe` 0 for TA_CYC cycles. It then holds `mem_we_n` low with `mem_dq_oe` 1 and `mem_dq_o` equal to the request data for WP_CYC cycles. WP_CYC is the ceiling of T_WP_PS / CLK_PERIOD_PS. `mem_we_n` and `mem_cs_n` rise, and `mem_dq_oe` falls, on the same edge.
- R6: A write asserts the byte enables of the masked lanes only, so unmasked lanes of the addressed word keep their contents.
- R7: `done` is high for exactly one cycle per request. Measured from the clock edge that accepts the request, it rises RD_CYC+TA_CYC edges later for a read and TA_CYC+WP_CYC edges later for a write.
- R8: A request with mask 0 raises `done` on the accepting edge without any memory strobe. For a read with mask 0, `rd_data` keeps its previous value.
- R9: A request is accepted only when the controller is idle and `done` is low. A request presented at any other time is ignored.
- R10: `mem_addr` does not change while `mem_cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mask | input | LANES | Lane select, bit 1 upper byte, bit 0 lower byte |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Captured read word |
| done | output | 1 | Request complete, one-cycle pulse |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_be_n | output | LANES | RAM byte enables, active low |
| mem_dq_o | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | DATA_W | Data from the RAM |

## Verification
The bench builds the controller with ADDR_W = 6 and a 20 ns clock. This gives a 64-word RAM model and phase lengths of 3 read-access, 3 write-pulse and 1 turnaround cycle. With a space that small, every word can be written, read back with each lane mask, and byte-patched. Every operation's latency, strobe widths and bus ownership are measured against the ceiling formulas. The RAM model returns garbage until the access time has elapsed, so sampling one cycle early is visible. A request injected mid-cycle, and zero-mask requests, cover the ignore and no-strobe paths.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REL,
    ST_WR_SET,
    ST_WR_PUL
  } seq_state_t;

  // Smallest whole number of clock periods covering a time in picoseconds.
  function automatic int ceil_cycles(input int t_ps, input int period_ps);
    int c;
    c = (t_ps + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= len - CNT_W'(1);
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int CNT_W  = 4,
  parameter int RD_LEN = 6,
  parameter int WP_LEN = 5,
  parameter int TA_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic [LANES-1:0] req_mask,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             accept,
  output logic             capture,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] be_n,
  output logic             dq_oe,
  output logic             done
);

  seq_state_t state, nxt;
  logic       finish;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_len  = CNT_W'(1);
    accept   = 1'b0;
    capture  = 1'b0;
    finish   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req && !done) begin
          accept = 1'b1;
          if (req_mask == '0) begin
            finish = 1'b1;
          end else if (req_wr) begin
            nxt      = ST_WR_SET;
            tmr_load = 1'b1;
            tmr_len  = CNT_W'(TA_LEN);
          end else begin
            nxt      = ST_RD_ACC;
            tmr_load = 1'b1;
            tmr_len  = CNT_W'(RD_LEN);
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_zero) begin
          capture  = 1'b1;
          nxt      = ST_RD_REL;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(TA_LEN);
        end
      end
      ST_RD_REL: begin
        if (tmr_zero) begin
          nxt    = ST_IDLE;
          finish = 1'b1;
        end
      end
      ST_WR_SET: begin
        if (tmr_zero) begin
          nxt      = ST_WR_PUL;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(WP_LEN);
        end
      end
      ST_WR_PUL: begin
        if (tmr_zero) begin
          nxt    = ST_IDLE;
          finish = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so every pin leaves a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cs_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      be_n  <= '1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
      cs_n  <= !(nxt == ST_RD_ACC || nxt == ST_WR_SET || nxt == ST_WR_PUL);
      oe_n  <= !(nxt == ST_RD_ACC);
      we_n  <= !(nxt == ST_WR_PUL);
      dq_oe <= (nxt == ST_WR_PUL);
      if (accept)
        be_n <= ~req_mask;
      else if (nxt == ST_IDLE)
        be_n <= '1;
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    capture,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        dout[g*LANE_W +: LANE_W] <= '0;
      else if (capture)
        dout[g*LANE_W +: LANE_W] <= lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int LANE_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_ACC_PS      = 55000,
  parameter int T_WP_PS       = 45000,
  parameter int T_HZ_PS       = 20000,
  localparam int LANES        = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [LANES-1:0]  req_mask,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_CYC  = ceil_cycles(T_ACC_PS, CLK_PERIOD_PS);
  localparam int WP_CYC  = ceil_cycles(T_WP_PS, CLK_PERIOD_PS);
  localparam int TA_CYC  = ceil_cycles(T_HZ_PS, CLK_PERIOD_PS);
  localparam int MAX_A   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_LEN = (MAX_A > TA_CYC) ? MAX_A : TA_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_len;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .len  (tmr_len),
    .zero (tmr_zero)
  );

  sram_lane_seq #(
    .LANES  (LANES),
    .CNT_W  (CNT_W),
    .RD_LEN (RD_CYC),
    .WP_LEN (WP_CYC),
    .TA_LEN (TA_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_wr   (req_wr),
    .req_mask (req_mask),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_len  (tmr_len),
    .accept   (accept),
    .capture  (capture),
    .cs_n     (mem_cs_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .be_n     (mem_be_n),
    .dq_oe    (mem_dq_oe),
    .done     (done)
  );

  // Address and write data are latched once per request and held.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  sram_rd_capture #(.LANES(LANES), .LANE_W(LANE_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .lane_en (~mem_be_n),
    .din     (mem_dq_i),
    .dout    (rd_data)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int RD_LEN = 6,
  parameter int WP_LEN = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [15:0] we_run, oe_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= !mem_we_n ? ((we_run == 16'hFFFF) ? we_run : we_run + 16'd1) : 16'd0;
      oe_run <= !mem_oe_n ? ((oe_run == 16'hFFFF) ? oe_run : oe_run + 16'd1) : 16'd0;
    end
  end

  AST_RD_ACCESS_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (32'(oe_run) >= RD_LEN)); // R2

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R4

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> $past(mem_oe_n)); // R4

  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (32'(we_run) >= WP_LEN)); // R5

  AST_DRIVE_DURING_WE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && !mem_cs_n)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R10

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .RD_LEN (RD_CYC),
  .WP_LEN (WP_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

  localparam int CLK_PS = 20000;
  localparam int AW     = 6;
  localparam int WORDS  = 1 << AW;
  localparam int E_RD   = (55000 + CLK_PS - 1) / CLK_PS;
  localparam int E_WP   = (45000 + CLK_PS - 1) / CLK_PS;
  localparam int E_TA   = (20000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PS / 2 * 1ps) clk = ~clk;

  logic          req = 1'b0, req_wr = 1'b0;
  logic [1:0]    req_mask = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [15:0]   rd_data, mem_dq_o, mem_dq_i;
  logic          done, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]    mem_be_n;
  logic [AW-1:0] mem_addr;

  sram_lane_ctrl #(
    .ADDR_W (AW), .DATA_W (16), .LANE_W (8), .CLK_PERIOD_PS (CLK_PS),
    .T_ACC_PS (55000), .T_WP_PS (45000), .T_HZ_PS (20000)
  ) dut (
    .clk (clk), .rst (rst), .req (req), .req_wr (req_wr),
    .req_mask (req_mask), .req_addr (req_addr), .req_wdata (req_wdata),
    .rd_data (rd_data), .done (done), .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
    .mem_be_n (mem_be_n), .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe),
    .mem_dq_i (mem_dq_i)
  );

  // RAM model: data becomes valid only after the access time has elapsed.
  logic [15:0] ram [WORDS];
  logic [15:0] shadow [WORDS];
  int rd_age = 0;
  int addr_moves = 0;
  logic          prev_cs_n = 1'b1;
  logic [AW-1:0] prev_addr = '0;

  always_ff @(posedge clk) begin
    rd_age <= (!mem_cs_n && !mem_oe_n) ? rd_age + 1 : 0;
    if (!mem_cs_n && !mem_we_n) begin
      for (int i = 0; i < 2; i++)
        if (!mem_be_n[i]) ram[mem_addr][i*8 +: 8] <= mem_dq_o[i*8 +: 8];
    end
    if (!rst && !mem_cs_n && !prev_cs_n && mem_addr != prev_addr)
      addr_moves <= addr_moves + 1;
    prev_cs_n <= mem_cs_n;
    prev_addr <= mem_addr;
  end

  always_comb begin
    mem_dq_i = 16'h5A5A;
    if (!mem_cs_n && !mem_oe_n && mem_we_n && rd_age >= E_RD - 1) begin
      for (int i = 0; i < 2; i++)
        mem_dq_i[i*8 +: 8] = mem_be_n[i] ? 8'hA5 : ram[mem_addr][i*8 +: 8];
    end
  end

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  int lat, we_cnt, oe_cnt, cs_cnt, fight, extra_done, drv_miss;
  logic [15:0] got;

  task automatic run_op(input bit wr, input logic [1:0] m, input int a,
                        input logic [15:0] d, input bit poke, input int poke_a);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_mask = m; req_addr = AW'(a); req_wdata = d;
    lat = 0; we_cnt = 0; oe_cnt = 0; cs_cnt = 0; fight = 0; drv_miss = 0;
    @(negedge clk);
    req = 1'b0;
    forever begin
      lat++;
      if (!mem_we_n) we_cnt++;
      if (!mem_we_n && !mem_dq_oe) drv_miss++;
      if (!mem_oe_n) oe_cnt++;
      if (!mem_cs_n) cs_cnt++;
      if (mem_dq_oe && !mem_oe_n) fight++;
      if (done || lat > 60) break;
      if (poke && lat == 2) begin
        req = 1'b1; req_wr = 1'b1; req_mask = 2'b11;
        req_addr = AW'(poke_a); req_wdata = 16'hFFFF;
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
    end
    got = rd_data;
    req = 1'b0;
    extra_done = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (done) extra_done++;
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    return {8'(a * 7 + 1), 8'(a * 13 + 5)};
  endfunction

  function automatic logic [15:0] lane_keep(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  initial begin
    for (int a = 0; a < WORDS; a++) begin
      ram[a] = '0;
      shadow[a] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset values
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    check(mem_be_n == 2'b11, "R1 be_n", mem_be_n, 2'b11);
    check(!mem_dq_oe && !done, "R1 dq_oe/done", {mem_dq_oe, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 16'h0 && mem_cs_n && !mem_dq_oe, "R1 after reset", rd_data, 0);

    // Full-word writes over the whole space
    for (int a = 0; a < WORDS; a++) begin
      run_op(1'b1, 2'b11, a, pat(a), 1'b0, 0);
      shadow[a] = pat(a);
      check(lat == E_TA + E_WP + 1, "R7 write latency", lat, E_TA + E_WP + 1);
      check(we_cnt == E_WP && drv_miss == 0, "R5 we pulse", we_cnt, E_WP);
      check(cs_cnt == E_TA + E_WP && oe_cnt == 0, "R5 cs window", cs_cnt, E_TA + E_WP);
      check(extra_done == 0, "R7 done width", extra_done, 0);
      check(fight == 0, "R4 bus fight", fight, 0);
    end

    // Full-word reads
    for (int a = 0; a < WORDS; a++) begin
      run_op(1'b0, 2'b11, a, 16'h0, 1'b0, 0);
      check(got == shadow[a], "R3 read word", got, shadow[a]);
      check(lat == E_RD + E_TA + 1, "R7 read latency", lat, E_RD + E_TA + 1);
      check(oe_cnt == E_RD && cs_cnt == E_RD && we_cnt == 0, "R2 access width", oe_cnt, E_RD);
      check(fight == 0, "R4 bus fight", fight, 0);
    end

    // Byte-lane writes, then reads with each mask
    for (int a = 0; a < WORDS; a++) begin
      logic [1:0] m;
      logic [15:0] d;
      m = (a % 2 == 1) ? 2'b10 : 2'b01;
      d = ~pat(a) ^ 16'h1234;
      run_op(1'b1, m, a, d, 1'b0, 0);
      if (m[1]) shadow[a][15:8] = d[15:8];
      if (m[0]) shadow[a][7:0]  = d[7:0];
      check(lat == E_TA + E_WP + 1, "R6 lane write latency", lat, E_TA + E_WP + 1);
    end
    for (int a = 0; a < WORDS; a++) begin
      for (int mi = 1; mi < 4; mi++) begin
        run_op(1'b0, 2'(mi), a, 16'h0, 1'b0, 0);
        check(got == lane_keep(shadow[a], 2'(mi)), "R6/R3 lane read", got,
              lane_keep(shadow[a], 2'(mi)));
      end
    end

    // Zero mask: no strobes, immediate done, memory and rd_data untouched
    run_op(1'b0, 2'b11, 5, 16'h0, 1'b0, 0);
    run_op(1'b1, 2'b00, 5, 16'hBEEF, 1'b0, 0);
    check(lat == 1 && cs_cnt == 0 && we_cnt == 0, "R8 zero-mask write", {lat[15:0], 8'(cs_cnt)}, {16'd1, 8'd0});
    run_op(1'b0, 2'b00, 9, 16'h0, 1'b0, 0);
    check(lat == 1 && cs_cnt == 0 && got == shadow[5], "R8 zero-mask read keeps rd_data", got, shadow[5]);
    run_op(1'b0, 2'b11, 5, 16'h0, 1'b0, 0);
    check(got == shadow[5], "R8 memory untouched", got, shadow[5]);

    // Request during a busy cycle is ignored
    run_op(1'b0, 2'b11, 10, 16'h0, 1'b1, 11);
    check(got == shadow[10] && extra_done == 0, "R9 busy read", got, shadow[10]);
    run_op(1'b0, 2'b11, 11, 16'h0, 1'b0, 0);
    check(got == shadow[11], "R9 ignored write left word", got, shadow[11]);

    check(addr_moves == 0, "R10 address held under cs", addr_moves, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule